// File: doc/BRIEF.md
# Serial Packet Framer with Whitening and CRC

The framer turns a stream of bytes, offered with a valid/ready handshake, into one serial bit per clock cycle with a strobe. A start pulse launches one packet. The packet is four preamble bytes, then a two-byte sync word, then an optional length byte, then the payload, then an optional two-byte checksum. Configuration is captured on the start pulse and held for the whole packet. Configuration changes and further start pulses have no effect until the framer is idle again.

There are two length modes. In fixed mode the payload length is the configured packet length. In variable mode the first byte taken from the stream is the payload length, and the configured value is the upper limit. The framer checks the length before it sends any bit. An illegal length raises a one-cycle length error, and nothing goes out.

Whitening, when enabled, scrambles every bit after the sync word with a 9-bit pseudo-random sequence. A payload byte that is not available at the moment it is needed ends the packet with an underflow flag.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset the framer is idle. `busy`, `bit_stb`, `in_ready`, `err_len` and `err_underflow` are all low.
- R2: Each packet starts with four bytes of 0xAA. These are followed by `cfg_sync[15:8]` and then `cfg_sync[7:0]`. Every byte is sent MSB first, and none of these six bytes is ever whitened.
- R3: In fixed mode (`cfg_var_len`=0) exactly `cfg_pkt_len` payload bytes are taken from the stream and sent. Bytes beyond that stay in the source. A `cfg_pkt_len` of 0 raises `err_len`, and no byte is taken.
- R4: In variable mode (`cfg_var_len`=1) the first stream byte is the payload length. It excludes itself and the checksum. It is sent right after the sync word, followed by that many payload bytes.
- R5: In variable mode a length byte of 0, or one above `cfg_pkt_len`, is consumed and raises a one-cycle `err_len`. No bit is emitted for that packet. A length equal to `cfg_pkt_len` is accepted.
- R6: With `cfg_crc_en`=1, two checksum bytes follow the payload, high byte first. The checksum is CRC-16, polynomial 0x8005, seeded 0xFFFF, MSB first, with no reflection and no final XOR. It covers the length byte (if any) and the payload, before whitening.
- R7: With `cfg_white_en`=1, each bit of the length byte, payload and checksum is XORed with the PN9 output. The 9-bit state s is seeded 0x1FF per packet. The output is s[0], and the next state is {s[0]^s[5], s[8:1]} (x^9+x^5+1). The state advances once per whitened bit.
- R8: A payload byte is fetched during the last bit of the byte before it. If `in_valid` is low then, `err_underflow` pulses for one cycle after that bit. The framer goes idle and emits no further bits.
- R9: `bit_stb` is high for each emitted bit, one bit per cycle without gaps from the first preamble bit to the last bit. `in_ready` is high only while waiting for the length byte or at a payload fetch point.
- R10: A start pulse or configuration change while `busy` is high has no effect on the packet in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| cfg_var_len | input | 1 | 1: variable length mode, 0: fixed |
| cfg_pkt_len | input | 8 | Fixed length, or maximum in variable mode |
| cfg_sync | input | 16 | Sync word, high byte sent first |
| cfg_crc_en | input | 1 | Append checksum |
| cfg_white_en | input | 1 | Whiten bits after the sync word |
| in_data | input | 8 | Source byte |
| in_valid | input | 1 | Source byte present |
| in_ready | output | 1 | Framer takes the byte this cycle |
| bit_out | output | 1 | Serial bit |
| bit_stb | output | 1 | `bit_out` carries a packet bit |
| busy | output | 1 | Packet in progress |
| err_len | output | 1 | One-cycle pulse: illegal length |
| err_underflow | output | 1 | One-cycle pulse: source ran dry mid-packet |

## Verification
The payload fetch and the emission of the last bit of the preceding byte fall in the same cycle. So the underflow decision and that bit's output coincide, and a checksum update is committed on the same edge. The bench provokes this by offering fewer payload bytes than the packet needs. It then judges that every bit up to and including the final bit of the last supplied byte came out and that the underflow pulse appeared. It also judges that no further strobe followed and that the source was drained. The same cycle is exercised on the good path with a one-byte payload, where fetch, checksum load and whitening start all crowd together.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_LENW, ST_SEND} fr_state_t;
  typedef enum logic [2:0] {SEG_PRE, SEG_SYNC, SEG_LEN, SEG_PAY, SEG_CRC} fr_seg_t;

  // one byte into a CRC-16, MSB first, non-reflected
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                             input logic [7:0]  d,
                                             input logic [15:0] poly);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  // x^9 + x^5 + 1, output taken from bit 0
  function automatic logic [8:0] pn9_next(input logic [8:0] s);
    return {s[0] ^ s[5], s[8:1]};
  endfunction
endpackage

// File: rtl/pn9_whitener.sv
module pn9_whitener
  import framer_pkg::*;
#(
  parameter logic [8:0] SEED = 9'h1FF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic step,
  output logic pn_bit
);
  logic [8:0] lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= SEED;
    else if (seed) lfsr <= SEED;
    else if (step) lfsr <= pn9_next(lfsr);
  end

  assign pn_bit = lfsr[0];

  AST_PN_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 9'd0);  // R7
  AST_PN_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> lfsr == SEED);  // R7
endmodule

// File: rtl/crc_accum.sv
module crc_accum
  import framer_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h8005,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= INIT;
    else if (clr)   crc <= INIT;
    else if (upd)   crc <= crc16_step(crc, din, POLY);
  end

  AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc == INIT);  // R6
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(crc));  // R6
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import framer_pkg::*;
#(
  parameter int          LEN_W       = 8,
  parameter int          PRE_BYTES   = 4,
  parameter logic [7:0]  PRE_PATTERN = 8'hAA,
  parameter logic [15:0] CRC_POLY    = 16'h8005,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [8:0]  PN_SEED     = 9'h1FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_var_len,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [15:0]      cfg_sync,
  input  logic             cfg_crc_en,
  input  logic             cfg_white_en,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             bit_out,
  output logic             bit_stb,
  output logic             busy,
  output logic             err_len,
  output logic             err_underflow
);
  localparam logic [LEN_W-1:0] CNT_ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] PRE_LAST = LEN_W'(PRE_BYTES - 1);

  fr_state_t        state;
  fr_seg_t          seg, nxt_seg;
  logic [LEN_W-1:0] cnt, nxt_cnt, len_q, pkt_len_q;
  logic [7:0]       sh, nxt_byte;
  logic [2:0]       bidx;
  logic             var_q, crc_en_q, white_q;
  logic [15:0]      sync_q;

  // named internal events
  logic        bit_last, need_fetch, load_len, pkt_end, fetch_miss;
  logic        white_on, crc_upd, pn_bit;
  logic [7:0]  crc_din;
  logic [15:0] crc_val;
  logic        len_bad;

  assign bit_last = (state == ST_SEND) && (bidx == 3'd7);

  // what comes after the byte now being shifted
  always_comb begin
    nxt_seg    = seg;
    nxt_cnt    = cnt + CNT_ONE;
    nxt_byte   = 8'h00;
    need_fetch = 1'b0;
    load_len   = 1'b0;
    pkt_end    = 1'b0;
    unique case (seg)
      SEG_PRE: begin
        if (cnt == PRE_LAST) begin
          nxt_seg  = SEG_SYNC;
          nxt_cnt  = '0;
          nxt_byte = sync_q[15:8];
        end else begin
          nxt_byte = PRE_PATTERN;
        end
      end
      SEG_SYNC: begin
        if (cnt == '0) begin
          nxt_byte = sync_q[7:0];
        end else if (var_q) begin
          nxt_seg  = SEG_LEN;
          nxt_cnt  = '0;
          nxt_byte = len_q[7:0];
          load_len = 1'b1;
        end else begin
          nxt_seg    = SEG_PAY;
          nxt_cnt    = '0;
          need_fetch = 1'b1;
        end
      end
      SEG_LEN: begin
        nxt_seg    = SEG_PAY;
        nxt_cnt    = '0;
        need_fetch = 1'b1;
      end
      SEG_PAY: begin
        if (cnt == len_q - CNT_ONE) begin
          if (crc_en_q) begin
            nxt_seg  = SEG_CRC;
            nxt_cnt  = '0;
            nxt_byte = crc_val[15:8];
          end else begin
            pkt_end = 1'b1;
          end
        end else begin
          need_fetch = 1'b1;
        end
      end
      SEG_CRC: begin
        if (cnt == '0) nxt_byte = crc_val[7:0];
        else           pkt_end  = 1'b1;
      end
      default: pkt_end = 1'b1;
    endcase
    if (need_fetch) nxt_byte = in_data;
  end

  assign fetch_miss = bit_last && need_fetch && !in_valid;
  assign in_ready   = (state == ST_LENW) || (bit_last && need_fetch);
  assign len_bad    = (in_data[LEN_W-1:0] == '0) || (in_data[LEN_W-1:0] > pkt_len_q);
  assign white_on   = (state == ST_SEND) && white_q &&
                      (seg == SEG_LEN || seg == SEG_PAY || seg == SEG_CRC);
  assign crc_upd    = bit_last && ((need_fetch && in_valid) || load_len);
  assign crc_din    = need_fetch ? in_data : len_q[7:0];

  assign bit_stb = (state == ST_SEND);
  assign bit_out = bit_stb ? (sh[7] ^ (white_on & pn_bit)) : 1'b0;
  assign busy    = (state != ST_IDLE);

  pn9_whitener #(.SEED(PN_SEED)) u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed   (state != ST_SEND),
    .step   (white_on),
    .pn_bit (pn_bit)
  );

  crc_accum #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == ST_IDLE),
    .upd   (crc_upd),
    .din   (crc_din),
    .crc   (crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      seg           <= SEG_PRE;
      cnt           <= '0;
      len_q         <= '0;
      pkt_len_q     <= '0;
      sh            <= '0;
      bidx          <= '0;
      var_q         <= 1'b0;
      crc_en_q      <= 1'b0;
      white_q       <= 1'b0;
      sync_q        <= '0;
      err_len       <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      err_len       <= 1'b0;
      err_underflow <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            var_q     <= cfg_var_len;
            crc_en_q  <= cfg_crc_en;
            white_q   <= cfg_white_en;
            sync_q    <= cfg_sync;
            pkt_len_q <= cfg_pkt_len;
            if (cfg_var_len) begin
              state <= ST_LENW;
            end else if (cfg_pkt_len == '0) begin
              err_len <= 1'b1;
            end else begin
              state <= ST_SEND;
              seg   <= SEG_PRE;
              cnt   <= '0;
              sh    <= PRE_PATTERN;
              bidx  <= '0;
              len_q <= cfg_pkt_len;
            end
          end
        end
        ST_LENW: begin
          if (in_valid) begin
            if (len_bad) begin
              err_len <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              state <= ST_SEND;
              seg   <= SEG_PRE;
              cnt   <= '0;
              sh    <= PRE_PATTERN;
              bidx  <= '0;
              len_q <= in_data[LEN_W-1:0];
            end
          end
        end
        ST_SEND: begin
          if (bidx != 3'd7) begin
            sh   <= {sh[6:0], 1'b0};
            bidx <= bidx + 3'd1;
          end else if (fetch_miss) begin
            err_underflow <= 1'b1;
            state         <= ST_IDLE;
          end else if (pkt_end) begin
            state <= ST_IDLE;
          end else begin
            seg  <= nxt_seg;
            cnt  <= nxt_cnt;
            sh   <= nxt_byte;
            bidx <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> !bit_stb);  // R5
  AST_UFLOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> (!bit_stb && !busy));  // R8
  AST_FETCH_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && bit_stb) |=> bit_stb);  // R9
  AST_STB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> busy);  // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable({var_q, crc_en_q, white_q, sync_q, pkt_len_q}));  // R10
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_len && err_underflow));  // R5
endmodule

// File: tb/sim_pkt_tx_framer.sv
module sim_pkt_tx_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_var_len = 1'b0;
  logic [7:0]  cfg_pkt_len = 8'd0;
  logic [15:0] cfg_sync = 16'hD391;
  logic        cfg_crc_en = 1'b0;
  logic        cfg_white_en = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_valid = 1'b0;
  logic        in_ready, bit_out, bit_stb, busy, err_len, err_underflow;

  always #10 clk = ~clk;  // 50 MHz

  pkt_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_var_len(cfg_var_len),
    .cfg_pkt_len(cfg_pkt_len), .cfg_sync(cfg_sync), .cfg_crc_en(cfg_crc_en),
    .cfg_white_en(cfg_white_en), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bit_out(bit_out), .bit_stb(bit_stb), .busy(busy),
    .err_len(err_len), .err_underflow(err_underflow)
  );

  logic [7:0] src_q[$];
  bit         exp_q[$];
  logic [7:0] pl[256];
  int         checks = 0, errs = 0;
  bit         seen_elen, seen_uf, hs_q;
  string      cur_tag = "R1";
  int         pn_s;
  int         crc_s;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) hs_q <= in_valid && in_ready;

  // source model and scoreboard monitor
  always @(negedge clk) begin
    if (hs_q && src_q.size() > 0) void'(src_q.pop_front());
    in_valid = (src_q.size() > 0);
    in_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    if (err_len) seen_elen = 1'b1;
    if (err_underflow) seen_uf = 1'b1;
    if (rst_n && bit_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected bit strobe", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(bit_out === e, cur_tag, "serial bit", int'(bit_out), int'(e));
      end
    end
  end

  task automatic crc_add(input logic [7:0] b);
    crc_s = crc_s ^ (int'(b) << 8);
    repeat (8) begin
      if (crc_s & 32'h8000) crc_s = ((crc_s << 1) ^ 32'h8005) & 32'hFFFF;
      else                  crc_s = (crc_s << 1) & 32'hFFFF;
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input bit wh);
    for (int i = 7; i >= 0; i--) begin
      int pb, fb;
      pb = 0;
      if (wh) begin
        pb   = pn_s & 1;
        fb   = (pn_s ^ (pn_s >> 5)) & 1;
        pn_s = (pn_s >> 1) | (fb << 8);
      end
      exp_q.push_back(b[i] ^ pb[0]);
    end
  endtask

  task automatic expect_pkt(input bit vm, input int len, input bit ce,
                            input bit we, input int nsent);
    pn_s  = 9'h1FF;
    crc_s = 16'hFFFF;
    for (int k = 0; k < 4; k++) push_byte(8'hAA, 1'b0);  // R2
    push_byte(cfg_sync[15:8], 1'b0);
    push_byte(cfg_sync[7:0], 1'b0);
    if (vm) begin
      push_byte(8'(len), we);  // R4
      crc_add(8'(len));
    end
    for (int k = 0; k < nsent; k++) begin
      push_byte(pl[k], we);
      crc_add(pl[k]);
    end
    if (ce && nsent == len) begin  // R6
      push_byte(8'(crc_s >> 8), we);
      push_byte(8'(crc_s), we);
    end
  endtask

  task automatic run(input string tag, input bit vm, input int plen, input int len,
                     input bit ce, input bit we, input int nsup, input int extra,
                     input bit x_elen, input bit x_uf, input bit poke);
    int exp_left;
    @(negedge clk);
    cur_tag      = tag;
    cfg_var_len  = vm;
    cfg_pkt_len  = 8'(plen);
    cfg_crc_en   = ce;
    cfg_white_en = we;
    for (int k = 0; k < 256; k++) pl[k] = 8'((k * 37 + plen * 11 + len * 5 + 13) & 8'hFF);
    if (vm) src_q.push_back(8'(len));
    for (int k = 0; k < nsup; k++) src_q.push_back(pl[k]);
    for (int k = 0; k < extra; k++) src_q.push_back(8'h5A);
    if (!x_elen) expect_pkt(vm, len, ce, we, x_uf ? nsup : len);
    seen_elen = 1'b0;
    seen_uf   = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R10
      repeat (40) @(negedge clk);
      cfg_sync     = 16'h0000;
      cfg_white_en = ~we;
      cfg_crc_en   = ~ce;
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy && i > 2) break;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, "bits left unsent", exp_q.size(), 0);
    chk(seen_elen == x_elen, x_elen ? "R5" : tag, "length error flag", int'(seen_elen), int'(x_elen));
    chk(seen_uf == x_uf, x_uf ? "R8" : tag, "underflow flag", int'(seen_uf), int'(x_uf));
    exp_left = x_uf ? 0 : (x_elen ? nsup + extra : extra);
    chk(src_q.size() == exp_left, tag, "source bytes left", src_q.size(), exp_left);
    chk(!busy && !bit_stb, tag, "idle after packet", int'(busy), 0);
    src_q.delete();
    exp_q.delete();
    cfg_sync = 16'hD391;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy after reset", int'(busy), 0);
    chk(!bit_stb, "R1", "bit_stb after reset", int'(bit_stb), 0);
    chk(!in_ready, "R1", "in_ready after reset", int'(in_ready), 0);
    chk(!err_len && !err_underflow, "R1", "error flags after reset",
        int'(err_len) + int'(err_underflow), 0);

    run("R2", 0, 3, 3, 0, 0, 3, 0, 0, 0, 0);   // plain fixed packet, preamble + sync
    run("R6", 0, 4, 4, 1, 0, 4, 0, 0, 0, 0);   // fixed with checksum
    run("R4", 1, 10, 5, 1, 1, 5, 0, 0, 0, 0);  // variable, checksum, whitening
    run("R7", 1, 8, 3, 0, 1, 3, 0, 0, 0, 0);   // variable, whitening only
    run("R5", 1, 8, 0, 0, 0, 0, 0, 1, 0, 0);   // variable, zero length
    run("R5", 1, 8, 9, 1, 0, 0, 0, 1, 0, 0);   // variable, length above limit
    run("R4", 1, 6, 6, 1, 1, 6, 0, 0, 0, 0);   // variable, length equal to limit
    run("R8", 0, 4, 4, 0, 0, 2, 0, 0, 1, 0);   // source runs dry after two bytes
    run("R8", 1, 9, 4, 1, 1, 1, 0, 0, 1, 0);   // dry after length byte and one payload byte
    run("R3", 0, 0, 0, 0, 0, 2, 0, 1, 0, 0);   // fixed, zero length
    run("R3", 0, 2, 2, 0, 0, 2, 3, 0, 0, 0);   // extra bytes stay in source
    run("R10", 0, 5, 5, 1, 1, 5, 0, 0, 0, 1);  // start and config change mid-packet
    run("R7", 0, 1, 1, 1, 1, 1, 0, 0, 0, 0);   // one-byte payload, whitened checksum
    run("R9", 1, 255, 40, 1, 0, 40, 2, 0, 0, 0); // long variable packet, contiguous strobe
    finish_run();
  end
endmodule